// File: doc/BRIEF.md
# Predicated Stateful Read-Add-Write Unit

This block keeps one state word and updates it atomically for each packet, at a rate of one packet per clock. Each packet brings two data fields. Static configuration inputs pick one of five update styles: write, add, add under a condition, pick between two add paths by a condition, and the same two-path form with a subtract on each path. Every packet leaves with the state value it found, and the new value is stored on the same clock edge. The next packet, even on the very next cycle, therefore sees the result.

The condition is an unsigned compare between two operands. Each operand is chosen from the two fields, a configured constant or the state. The arithmetic on each path starts from a base, which is either the state or zero. It adds one operand chosen from the two fields, the constant or zero. In subtract style it also takes away a second operand chosen from the same set. Results wrap modulo the state width. A packet is marked by a valid strobe, and its result appears one cycle later.

Top module: `stateful_rmw_unit`

## Requirements
- R1: A synchronous reset sets the state to zero and drives `out_valid` low. The first packet after reset reads an old value of 0.
- R2: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. In that cycle `out_old` holds the state value from before that packet's update.
- R3: In write mode (`cfg_mode`=0) the state becomes the operand chosen by `cfg_t_add`. The operand codes are 0=field 1, 1=field 2, 2=constant, 3=zero.
- R4: In add mode (`cfg_mode`=1) the state becomes the true-path base plus the true-path add operand. The base is 0 for state when `cfg_t_zero`=0 and zero when `cfg_t_zero`=1.
- R5: In conditional add mode (`cfg_mode`=2) the true-path sum is stored when the condition holds. Otherwise the state is kept.
- R6: In two-path mode (`cfg_mode`=3) the true path is stored when the condition holds and the false path when it fails. The false path is built from `cfg_f_zero` and `cfg_f_add`.
- R7: In subtract mode (`cfg_mode`=4) the chosen path also subtracts its sub operand (`cfg_t_sub` or `cfg_f_sub`, same codes as R3). In all other modes the sub operands have no effect.
- R8: The condition is reported on `out_pred`. Operand codes are 0=field 1, 1=field 2, 2=constant, 3=state. Compare codes are 0 ==, 1 !=, 2 <, 3 <=, 4 >, 5 >=, and 6/7 are always false. All compares are unsigned.
- R9: All adds and subtracts wrap modulo 2^W.
- R10: A cycle with `in_valid` low leaves the state unchanged, whatever the configuration inputs are.
- R11: Packets on consecutive cycles each see the update made by the one before.
- R12: Mode codes 5 to 7 leave the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 3 | Update style |
| cfg_relop | input | 3 | Compare operator |
| cfg_cmp_lhs | input | 2 | Left compare operand select |
| cfg_cmp_rhs | input | 2 | Right compare operand select |
| cfg_imm | input | W | Configured constant |
| cfg_t_zero | input | 1 | True path base is zero |
| cfg_t_add | input | 2 | True path add/write operand |
| cfg_t_sub | input | 2 | True path subtract operand |
| cfg_f_zero | input | 1 | False path base is zero |
| cfg_f_add | input | 2 | False path add operand |
| cfg_f_sub | input | 2 | False path subtract operand |
| in_valid | input | 1 | Packet present |
| in_f1 | input | W | Packet field 1 |
| in_f2 | input | W | Packet field 2 |
| out_valid | output | 1 | Result present |
| out_old | output | W | State before this packet's update |
| out_pred | output | 1 | Condition result for this packet |

## Verification
The bench aims at the boundaries of each compare. Equal operands under <= and >= expose an off-by-one operator, which would let a conditional add fire or skip wrongly and shift every later old value. A subtract that goes below zero, followed by an add that crosses the top, catches arithmetic that saturates or drops the carry. Further checks cover an idle cycle with write configuration applied, an unused mode code, and a reset mid-stream. These would expose a design that updates without a strobe, treats spare codes as writes, or keeps the old state through reset.

// File: rtl/stateful_rmw_unit.sv
module stateful_rmw_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   cfg_mode,
  input  logic [2:0]   cfg_relop,
  input  logic [1:0]   cfg_cmp_lhs,
  input  logic [1:0]   cfg_cmp_rhs,
  input  logic [W-1:0] cfg_imm,
  input  logic         cfg_t_zero,
  input  logic [1:0]   cfg_t_add,
  input  logic [1:0]   cfg_t_sub,
  input  logic         cfg_f_zero,
  input  logic [1:0]   cfg_f_add,
  input  logic [1:0]   cfg_f_sub,
  input  logic         in_valid,
  input  logic [W-1:0] in_f1,
  input  logic [W-1:0] in_f2,
  output logic         out_valid,
  output logic [W-1:0] out_old,
  output logic         out_pred
);
  localparam logic [2:0] MODE_WR  = 3'd0;
  localparam logic [2:0] MODE_ADD = 3'd1;
  localparam logic [2:0] MODE_CND = 3'd2;
  localparam logic [2:0] MODE_TWO = 3'd3;
  localparam logic [2:0] MODE_SUB = 3'd4;
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] st, nxt;
  logic [W-1:0] lhs, rhs;
  logic [W-1:0] t_sum, f_sum;
  logic         pred;

  function automatic logic [W-1:0] pick(input logic [1:0] s, input logic [W-1:0] a,
                                        input logic [W-1:0] b, input logic [W-1:0] c,
                                        input logic [W-1:0] d);
    case (s)
      2'd0:    pick = a;
      2'd1:    pick = b;
      2'd2:    pick = c;
      default: pick = d;
    endcase
  endfunction

  assign lhs = pick(cfg_cmp_lhs, in_f1, in_f2, cfg_imm, st);
  assign rhs = pick(cfg_cmp_rhs, in_f1, in_f2, cfg_imm, st);

  always_comb begin
    case (cfg_relop)
      3'd0:    pred = (lhs == rhs);
      3'd1:    pred = (lhs != rhs);
      3'd2:    pred = (lhs <  rhs);
      3'd3:    pred = (lhs <= rhs);
      3'd4:    pred = (lhs >  rhs);
      3'd5:    pred = (lhs >= rhs);
      default: pred = 1'b0;
    endcase
  end

  assign t_sum = (cfg_t_zero ? ZERO : st) + pick(cfg_t_add, in_f1, in_f2, cfg_imm, ZERO)
               - ((cfg_mode == MODE_SUB) ? pick(cfg_t_sub, in_f1, in_f2, cfg_imm, ZERO) : ZERO);
  assign f_sum = (cfg_f_zero ? ZERO : st) + pick(cfg_f_add, in_f1, in_f2, cfg_imm, ZERO)
               - ((cfg_mode == MODE_SUB) ? pick(cfg_f_sub, in_f1, in_f2, cfg_imm, ZERO) : ZERO);

  always_comb begin
    case (cfg_mode)
      MODE_WR:            nxt = pick(cfg_t_add, in_f1, in_f2, cfg_imm, ZERO);
      MODE_ADD:           nxt = t_sum;
      MODE_CND:           nxt = pred ? t_sum : st;
      MODE_TWO, MODE_SUB: nxt = pred ? t_sum : f_sum;
      default:            nxt = st;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= '0;
      out_valid <= 1'b0;
      out_old   <= '0;
      out_pred  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_old  <= st;
        out_pred <= pred;
        st       <= nxt;
      end
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (st == '0 && !out_valid));
  p_valid_lat_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_old_value_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_old == $past(st));
  p_cond_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cfg_mode == MODE_CND && !pred) |=> st == $past(st));
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(st));
  p_spare_mode_r12: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cfg_mode > MODE_SUB) |=> $stable(st));
endmodule

// File: tb/test_stateful_rmw_unit.sv
`timescale 1ns/1ps
module test_stateful_rmw_unit;
  localparam int W = 16;
  localparam int N = 13;

  typedef struct packed {
    logic [2:0] mode; logic [2:0] rel; logic [1:0] ca; logic [1:0] cb;
    logic [15:0] imm;
    logic tz; logic [1:0] ta; logic [1:0] ts;
    logic fz; logic [1:0] fa; logic [1:0] fs;
    logic [15:0] f1; logic [15:0] f2;
    logic [15:0] old; logic pred;
  } vec_t;

  // mode rel ca cb imm  tz ta ts  fz fa fs  f1 f2  expected_old expected_pred
  localparam vec_t VEC [N] = '{
    '{3'd0, 3'd0, 2'd3, 2'd2, 16'd0,  1'b0, 2'd0, 2'd3, 1'b0, 2'd3, 2'd3, 16'd100, 16'd7,  16'd0,    1'b1},
    '{3'd0, 3'd1, 2'd3, 2'd2, 16'd55, 1'b0, 2'd2, 2'd3, 1'b0, 2'd3, 2'd3, 16'd1,   16'd2,  16'd100,  1'b1},
    '{3'd1, 3'd2, 2'd3, 2'd0, 16'd0,  1'b0, 2'd1, 2'd3, 1'b0, 2'd3, 2'd3, 16'd60,  16'd10, 16'd55,   1'b1},
    '{3'd1, 3'd3, 2'd3, 2'd1, 16'd0,  1'b1, 2'd0, 2'd3, 1'b0, 2'd3, 2'd3, 16'd9,   16'd65, 16'd65,   1'b1},
    '{3'd2, 3'd4, 2'd3, 2'd2, 16'd20, 1'b0, 2'd2, 2'd3, 1'b0, 2'd3, 2'd3, 16'd0,   16'd0,  16'd9,    1'b0},
    '{3'd2, 3'd5, 2'd3, 2'd2, 16'd9,  1'b0, 2'd2, 2'd0, 1'b0, 2'd3, 2'd3, 16'd5,   16'd0,  16'd9,    1'b1},
    '{3'd3, 3'd2, 2'd0, 2'd1, 16'd0,  1'b0, 2'd0, 2'd1, 1'b1, 2'd1, 2'd0, 16'd3,   16'd4,  16'd18,   1'b1},
    '{3'd3, 3'd2, 2'd0, 2'd1, 16'd0,  1'b0, 2'd0, 2'd1, 1'b1, 2'd1, 2'd0, 16'd5,   16'd4,  16'd21,   1'b0},
    '{3'd4, 3'd0, 2'd3, 2'd2, 16'd4,  1'b0, 2'd3, 2'd0, 1'b0, 2'd2, 2'd1, 16'd1,   16'd10, 16'd4,    1'b1},
    '{3'd4, 3'd0, 2'd3, 2'd2, 16'd4,  1'b0, 2'd3, 2'd0, 1'b0, 2'd2, 2'd1, 16'd1,   16'd10, 16'd3,    1'b0},
    '{3'd1, 3'd6, 2'd0, 2'd0, 16'd0,  1'b0, 2'd0, 2'd3, 1'b0, 2'd3, 2'd3, 16'd5,   16'd0,  16'hFFFD, 1'b0},
    '{3'd5, 3'd7, 2'd0, 2'd0, 16'd9,  1'b1, 2'd2, 2'd3, 1'b1, 2'd2, 2'd3, 16'd7,   16'd7,  16'd2,    1'b0},
    '{3'd0, 3'd0, 2'd0, 2'd1, 16'd0,  1'b0, 2'd1, 2'd3, 1'b0, 2'd3, 2'd3, 16'h1234,16'h1234,16'd2,   1'b1}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] cfg_mode = '0, cfg_relop = '0;
  logic [1:0] cfg_cmp_lhs = '0, cfg_cmp_rhs = '0;
  logic [W-1:0] cfg_imm = '0;
  logic cfg_t_zero = 1'b0, cfg_f_zero = 1'b0;
  logic [1:0] cfg_t_add = '0, cfg_t_sub = '0, cfg_f_add = '0, cfg_f_sub = '0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_f1 = '0, in_f2 = '0;
  logic out_valid, out_pred;
  logic [W-1:0] out_old;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  stateful_rmw_unit #(.W(W)) i_stateful_rmw_unit (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_relop(cfg_relop),
    .cfg_cmp_lhs(cfg_cmp_lhs), .cfg_cmp_rhs(cfg_cmp_rhs), .cfg_imm(cfg_imm),
    .cfg_t_zero(cfg_t_zero), .cfg_t_add(cfg_t_add), .cfg_t_sub(cfg_t_sub),
    .cfg_f_zero(cfg_f_zero), .cfg_f_add(cfg_f_add), .cfg_f_sub(cfg_f_sub),
    .in_valid(in_valid), .in_f1(in_f1), .in_f2(in_f2),
    .out_valid(out_valid), .out_old(out_old), .out_pred(out_pred));

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    cfg_mode = v.mode; cfg_relop = v.rel; cfg_cmp_lhs = v.ca; cfg_cmp_rhs = v.cb;
    cfg_imm = v.imm; cfg_t_zero = v.tz; cfg_t_add = v.ta; cfg_t_sub = v.ts;
    cfg_f_zero = v.fz; cfg_f_add = v.fa; cfg_f_sub = v.fs;
    in_f1 = v.f1; in_f2 = v.f2; in_valid = vld;
  endtask

  function automatic string tag_of(input int i, input logic [2:0] m);
    if (i == 10) return "R9";
    case (m)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R12";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {15'd0, out_valid}, 16'd0);
    rst = 1'b0;
    // R11: the table runs back-to-back, one packet per cycle; each new
    // state value is observed as the next packet's old value.
    for (int i = 0; i <= N; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check("R2", {15'd0, out_valid}, 16'd1);
        check(tag_of(i - 1, VEC[i-1].mode), out_old, VEC[i-1].old);
        check("R8", {15'd0, out_pred}, {15'd0, VEC[i-1].pred});
      end
      if (i < N) drive(VEC[i], 1'b1);
      else in_valid = 1'b0;
    end
    // R10: idle cycle with a write configuration must not touch the state
    drive('{3'd0, 3'd0, 2'd0, 2'd0, 16'd0, 1'b0, 2'd2, 2'd3, 1'b0, 2'd3, 2'd3,
            16'd0, 16'd0, 16'd0, 1'b0}, 1'b0);
    cfg_imm = 16'h0BAD;
    @(negedge clk);
    check("R2", {15'd0, out_valid}, 16'd0);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10", out_old, 16'h1234);
    // R1: reset mid-stream clears the state
    rst = 1'b1;
    @(negedge clk);
    check("R1", {15'd0, out_valid}, 16'd0);
    rst = 1'b0;
    drive('{3'd1, 3'd0, 2'd0, 2'd0, 16'd0, 1'b0, 2'd0, 2'd3, 1'b0, 2'd3, 2'd3,
            16'd3, 16'd0, 16'd0, 1'b0}, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1", out_old, 16'd0);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R4", out_old, 16'd3);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule